// File: doc/BRIEF.md
# Focus Capture and Supervision Sequencer

This block brings an optical pickup's focus loop from open search to closed loop, and then keeps watch over it. After a start command it sweeps a triangular search ramp around a programmable centre. It first qualifies the light level on the central-aperture (CA) sum, and then the size of the normalised focus error (FE). It closes the loop only when FE next passes through zero. Every decision is taken on a sample strobe that accompanies each new CA/FE pair.

Once the loop is closed, a fall of CA below the drop level clears the focus-good flag and holds the loop integrator, on the assumption that the disc has a short surface defect. If the flag stays false for more strobes than a programmable limit, focus is declared lost. The sequencer then passes through a one-strobe restart state and starts searching again from the ramp centre. A limit of about 12700 strobes gives roughly 3 ms at a 4.2336 MHz strobe rate. While the loop is closed, the loop gain can be stepped up or down by a factor of two. Each step comes with a pulse that tells the external filter how to rescale its integrator. The filter itself lies outside this block. The configuration inputs are expected to stay constant outside the idle state.

Top module: `focus_acq_ctrl`

## Requirements
- R1: After reset, and in the idle state, `state_o` is 0, `ramp_out` is 0 and `fok`, `pid_en`, `int_hold`, `focus_lost`, `int_div2`, `int_mul2` and `gain_lvl` are all 0. A `start_cmd` in the idle state moves the block to the ramp state on the next clock, with `ramp_out` equal to `cfg_ramp_ofs` and the ramp rising. The state codes are: idle 0, ramp 1, armed 2, locked 3, dropout 4, restart 5.
- R2: In the ramp and armed states, each strobe adds `cfg_ramp_step` to the ramp while it rises, or subtracts it while it falls. A rising step that would reach or pass `cfg_ramp_ofs + cfg_ramp_hgt` stops at that value and turns the ramp downward. A falling step that would reach or pass `cfg_ramp_ofs - cfg_ramp_hgt` stops at that value and turns the ramp upward. Without a strobe, the ramp holds.
- R3: On each strobe outside the idle state, `fok` becomes 0 if `ca_smp < cfg_ca_drop`. Otherwise it becomes 1 if `ca_smp >= cfg_ca_start`. Otherwise it keeps its value.
- R4: In the ramp state, a strobe on which the updated focus-good value is true and |`fe_smp`| >= `cfg_fe_start` moves the block to the armed state.
- R5: In the armed state, a strobe whose FE is zero, or whose sign differs from that of the previous strobe's FE, moves the block to the locked state, where `pid_en` is 1. A strobe on which the updated focus-good value is false returns the block to the ramp state instead.
- R6: In the locked and dropout states, `ramp_out` does not change.
- R7: In the locked state, a strobe with a false focus-good value moves the block to the dropout state. There `int_hold` and `pid_en` are both 1. A strobe with a true focus-good value returns the block to the locked state.
- R8: When the focus-good value has been false on `cfg_loss_lim`+1 consecutive strobes since the loop was locked, the block enters the restart state on that last strobe. It stays there for exactly one strobe, with `focus_lost` at 1, `pid_en` at 0 and `ramp_out` reloaded to `cfg_ramp_ofs`. The next strobe moves it to the ramp state.
- R9: In the locked state, `gain_up_cmd` alone raises `gain_lvl` (a signed value from -1 to +1) by one and pulses `int_div2` for one cycle. `gain_dn_cmd` alone lowers it by one and pulses `int_mul2`. A command at the limit, both commands together, or a command outside the locked state changes nothing. The decision uses the state held before the clock edge.
- R10: `stop_cmd` returns the block to the idle state on the next clock from any state, and takes priority over `start_cmd`, strobes and gain commands. Outside the idle state, `start_cmd` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_cmd | input | 1 | Begin capture from idle |
| stop_cmd | input | 1 | Return to idle |
| smp_vld | input | 1 | New CA/FE sample strobe |
| ca_smp | input | DW | Central-aperture sum, unsigned |
| fe_smp | input | DW | Normalised focus error, signed |
| cfg_ramp_ofs | input | RW | Ramp centre, signed |
| cfg_ramp_hgt | input | RW | Ramp half-swing, unsigned |
| cfg_ramp_step | input | RW | Ramp change per strobe |
| cfg_ca_start | input | DW | CA level that sets focus-good |
| cfg_ca_drop | input | DW | CA level below which focus-good clears |
| cfg_fe_start | input | DW | FE magnitude needed to arm |
| cfg_loss_lim | input | TW | False strobes tolerated before loss |
| gain_up_cmd | input | 1 | Double the loop gain |
| gain_dn_cmd | input | 1 | Halve the loop gain |
| ramp_out | output | RW | Search ramp value, signed |
| fok | output | 1 | Focus-good flag |
| pid_en | output | 1 | Focus filter enable |
| int_hold | output | 1 | Freeze the filter integrator |
| focus_lost | output | 1 | High during the restart state |
| state_o | output | 3 | Sequencer state code |
| gain_lvl | output | 2 | Gain step, signed, -1 to +1 |
| int_div2 | output | 1 | One-cycle pulse: halve the integrator |
| int_mul2 | output | 1 | One-cycle pulse: double the integrator |

## Verification
A gain-step command can arrive on the same clock edge as a strobe that ends the locked state, and a stop can arrive together with a strobe or a start. The bench drives a gain command on the exact strobe that drops CA below the drop level. By R9, the gain must still change, because the state before the edge was locked. It also drives stop together with a strobe and together with start, and expects the idle state. A behavioural reference model updated on every clock predicts every output, so any disagreement in those shared cycles shows up at once.

// File: rtl/focus_acq_ctrl.sv
module focus_acq_ctrl #(
  parameter int DW = 16,
  parameter int RW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_cmd,
  input  logic                 stop_cmd,
  input  logic                 smp_vld,
  input  logic [DW-1:0]        ca_smp,
  input  logic signed [DW-1:0] fe_smp,
  input  logic signed [RW-1:0] cfg_ramp_ofs,
  input  logic [RW-1:0]        cfg_ramp_hgt,
  input  logic [RW-1:0]        cfg_ramp_step,
  input  logic [DW-1:0]        cfg_ca_start,
  input  logic [DW-1:0]        cfg_ca_drop,
  input  logic [DW-1:0]        cfg_fe_start,
  input  logic [TW-1:0]        cfg_loss_lim,
  input  logic                 gain_up_cmd,
  input  logic                 gain_dn_cmd,
  output logic signed [RW-1:0] ramp_out,
  output logic                 fok,
  output logic                 pid_en,
  output logic                 int_hold,
  output logic                 focus_lost,
  output logic [2:0]           state_o,
  output logic signed [1:0]    gain_lvl,
  output logic                 int_div2,
  output logic                 int_mul2
);
  localparam int EW = RW + 2;
  localparam logic [2:0] S_IDLE = 3'd0, S_RAMP = 3'd1, S_ARMED = 3'd2,
                         S_LOCKED = 3'd3, S_DROP = 3'd4, S_RESTART = 3'd5;

  logic [2:0]           st_q;
  logic signed [RW-1:0] ramp_q;
  logic                 dir_q;
  logic                 fok_q;
  logic [TW-1:0]        loss_q;
  logic signed [DW-1:0] fe_prev_q;
  logic signed [1:0]    lvl_q;
  logic                 div2_q, mul2_q;

  // focus-good value after this sample, with hysteresis between the two levels
  logic fok_n;
  assign fok_n = (ca_smp < cfg_ca_drop) ? 1'b0 : ((ca_smp >= cfg_ca_start) ? 1'b1 : fok_q);

  logic [DW:0] fe_mag;
  logic        fe_hit, fe_xing;
  assign fe_mag  = fe_smp[DW-1] ? (~{1'b1, fe_smp} + 1'b1) : {1'b0, fe_smp};
  assign fe_hit  = fe_mag >= {1'b0, cfg_fe_start};
  assign fe_xing = (fe_smp == '0) || (fe_smp[DW-1] != fe_prev_q[DW-1]);

  logic signed [EW-1:0] ofs_x, hgt_x, step_x, ramp_x, top_x, bot_x, up_x, dn_x, nxt_x;
  logic                 dir_n;
  assign ofs_x  = {{2{cfg_ramp_ofs[RW-1]}}, cfg_ramp_ofs};
  assign hgt_x  = {2'b00, cfg_ramp_hgt};
  assign step_x = {2'b00, cfg_ramp_step};
  assign ramp_x = {{2{ramp_q[RW-1]}}, ramp_q};
  assign top_x  = ofs_x + hgt_x;
  assign bot_x  = ofs_x - hgt_x;
  assign up_x   = ramp_x + step_x;
  assign dn_x   = ramp_x - step_x;

  always_comb begin
    nxt_x = ramp_x;
    dir_n = dir_q;
    if (!dir_q) begin
      if (up_x >= top_x) begin nxt_x = top_x; dir_n = 1'b1; end
      else nxt_x = up_x;
    end else begin
      if (dn_x <= bot_x) begin nxt_x = bot_x; dir_n = 1'b0; end
      else nxt_x = dn_x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fe_prev_q <= '0;
    else if (smp_vld) fe_prev_q <= fe_smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ramp_q <= '0;
      dir_q  <= 1'b0;
      fok_q  <= 1'b0;
      loss_q <= '0;
      lvl_q  <= '0;
      div2_q <= 1'b0;
      mul2_q <= 1'b0;
    end else begin
      div2_q <= 1'b0;
      mul2_q <= 1'b0;
      if ((gain_up_cmd ^ gain_dn_cmd) && st_q == S_LOCKED) begin
        if (gain_up_cmd && lvl_q != 2'sd1) begin
          lvl_q  <= lvl_q + 2'sd1;
          div2_q <= 1'b1;
        end
        if (gain_dn_cmd && lvl_q != -2'sd1) begin
          lvl_q  <= lvl_q - 2'sd1;
          mul2_q <= 1'b1;
        end
      end
      if (stop_cmd) begin
        st_q   <= S_IDLE;
        ramp_q <= '0;
        dir_q  <= 1'b0;
        fok_q  <= 1'b0;
        loss_q <= '0;
        lvl_q  <= '0;
        div2_q <= 1'b0;
        mul2_q <= 1'b0;
      end else if (st_q == S_IDLE) begin
        if (start_cmd) begin
          st_q   <= S_RAMP;
          ramp_q <= cfg_ramp_ofs;
          dir_q  <= 1'b0;
          lvl_q  <= '0;
        end
      end else if (smp_vld) begin
        fok_q <= fok_n;
        case (st_q)
          S_RAMP: begin
            ramp_q <= nxt_x[RW-1:0];
            dir_q  <= dir_n;
            if (fok_n && fe_hit) st_q <= S_ARMED;
          end
          S_ARMED: begin
            ramp_q <= nxt_x[RW-1:0];
            dir_q  <= dir_n;
            if (!fok_n) st_q <= S_RAMP;
            else if (fe_xing) st_q <= S_LOCKED;
          end
          S_LOCKED: begin
            if (!fok_n) begin
              st_q   <= S_DROP;
              loss_q <= {{(TW-1){1'b0}}, 1'b1};
            end else loss_q <= '0;
          end
          S_DROP: begin
            if (fok_n) begin
              st_q   <= S_LOCKED;
              loss_q <= '0;
            end else if (loss_q >= cfg_loss_lim) begin
              st_q   <= S_RESTART;
              loss_q <= '0;
              ramp_q <= cfg_ramp_ofs;
              dir_q  <= 1'b0;
            end else loss_q <= loss_q + {{(TW-1){1'b0}}, 1'b1};
          end
          S_RESTART: st_q <= S_RAMP;
          default:   st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign ramp_out   = ramp_q;
  assign fok        = fok_q;
  assign pid_en     = (st_q == S_LOCKED) || (st_q == S_DROP);
  assign int_hold   = (st_q == S_DROP);
  assign focus_lost = (st_q == S_RESTART);
  assign state_o    = st_q;
  assign gain_lvl   = lvl_q;
  assign int_div2   = div2_q;
  assign int_mul2   = mul2_q;

  assert_ramp_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RAMP || st_q == S_ARMED) |-> (ramp_x >= bot_x && ramp_x <= top_x));
  assert_lock_from_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pid_en) |-> $past(st_q) == S_ARMED);
  assert_ramp_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pid_en && $past(pid_en) && !$past(stop_cmd)) |-> $stable(ramp_q));
  assert_hold_without_fok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_hold |-> !fok);
  assert_loss_after_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(focus_lost) |-> ($past(st_q) == S_DROP && $past(loss_q) >= $past(cfg_loss_lim)));
  assert_one_rescale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_div2, int_mul2}));
  assert_rescale_when_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_div2 || int_mul2) |-> $past(st_q) == S_LOCKED);
  assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> st_q == S_IDLE);
endmodule

// File: tb/focus_acq_ctrl_bench.sv
module focus_acq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_cmd = 0, stop_cmd = 0, smp_vld = 0, gain_up_cmd = 0, gain_dn_cmd = 0;
  logic [15:0] ca_smp = '0;
  logic signed [15:0] fe_smp = '0;
  logic signed [15:0] cfg_ramp_ofs = 16'sd100;
  logic [15:0] cfg_ramp_hgt = 16'd40, cfg_ramp_step = 16'd15;
  logic [15:0] cfg_ca_start = 16'd500, cfg_ca_drop = 16'd300, cfg_fe_start = 16'd200;
  logic [15:0] cfg_loss_lim = 16'd5;
  logic signed [15:0] ramp_out;
  logic fok, pid_en, int_hold, focus_lost, int_div2, int_mul2;
  logic [2:0] state_o;
  logic signed [1:0] gain_lvl;

  int checks = 0, fails = 0;
  string req = "R1";
  int m_st = 0, m_ramp = 0, m_dir = 0, m_fok = 0, m_loss = 0, m_lvl = 0, m_prev = 0, m_div = 0, m_mul = 0;

  always #5 clk = ~clk;

  focus_acq_ctrl u_focus_acq_ctrl (.*);

  task automatic chk(input string r, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(req, "state", int'(state_o), m_st);
    chk(req, "ramp", int'(ramp_out), m_ramp);
    chk(req, "fok", int'(fok), m_fok);
    chk(req, "pid_en", int'(pid_en), int'(m_st == 3 || m_st == 4));
    chk(req, "int_hold", int'(int_hold), int'(m_st == 4));
    chk(req, "focus_lost", int'(focus_lost), int'(m_st == 5));
    chk(req, "gain_lvl", int'(gain_lvl), m_lvl);
    chk(req, "int_div2", int'(int_div2), m_div);
    chk(req, "int_mul2", int'(int_mul2), m_mul);
  endtask

  task automatic model();
    int ofs, top, bot, fokn, hit, xing, fe, ca;
    ofs = int'(cfg_ramp_ofs); top = ofs + int'(cfg_ramp_hgt); bot = ofs - int'(cfg_ramp_hgt);
    fe = int'(fe_smp); ca = int'(ca_smp);
    m_div = 0; m_mul = 0;
    if (gain_up_cmd != gain_dn_cmd && m_st == 3) begin
      if (gain_up_cmd && m_lvl < 1) begin m_lvl++; m_div = 1; end
      if (gain_dn_cmd && m_lvl > -1) begin m_lvl--; m_mul = 1; end
    end
    if (stop_cmd) begin
      m_st = 0; m_ramp = 0; m_dir = 0; m_fok = 0; m_loss = 0; m_lvl = 0; m_div = 0; m_mul = 0;
    end else if (m_st == 0) begin
      if (start_cmd) begin m_st = 1; m_ramp = ofs; m_dir = 0; m_lvl = 0; end
    end else if (smp_vld) begin
      fokn = (ca < int'(cfg_ca_drop)) ? 0 : ((ca >= int'(cfg_ca_start)) ? 1 : m_fok);
      hit  = ((fe < 0 ? -fe : fe) >= int'(cfg_fe_start));
      xing = (fe == 0) || ((fe < 0) != (m_prev < 0));
      m_fok = fokn;
      if (m_st == 1 || m_st == 2) begin
        if (m_dir == 0) begin
          if (m_ramp + int'(cfg_ramp_step) >= top) begin m_ramp = top; m_dir = 1; end
          else m_ramp += int'(cfg_ramp_step);
        end else begin
          if (m_ramp - int'(cfg_ramp_step) <= bot) begin m_ramp = bot; m_dir = 0; end
          else m_ramp -= int'(cfg_ramp_step);
        end
      end
      case (m_st)
        1: if (fokn && hit) m_st = 2;
        2: if (!fokn) m_st = 1; else if (xing) m_st = 3;
        3: if (!fokn) begin m_st = 4; m_loss = 1; end else m_loss = 0;
        4: if (fokn) begin m_st = 3; m_loss = 0; end
           else if (m_loss >= int'(cfg_loss_lim)) begin m_st = 5; m_loss = 0; m_ramp = ofs; m_dir = 0; end
           else m_loss++;
        5: m_st = 1;
        default: m_st = 0;
      endcase
    end
    if (smp_vld) m_prev = fe;
  endtask

  task automatic step(input bit st, input bit sp, input bit v, input int ca, input int fe,
                      input bit gu = 0, input bit gd = 0);
    @(negedge clk);
    start_cmd = st; stop_cmd = sp; smp_vld = v; ca_smp = 16'(ca); fe_smp = 16'(fe);
    gain_up_cmd = gu; gain_dn_cmd = gd;
    model();
    @(posedge clk); #2;
    compare();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2 compare();
    rst_n = 1'b1;
    step(0, 0, 1, 0, 0);
    // R1 start, R2 triangle sweep, holding without strobes
    req = "R1"; step(1, 0, 0, 0, 0);
    req = "R2";
    for (int i = 0; i < 14; i++) step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    // R10 start ignored outside idle
    req = "R10"; step(1, 0, 1, 0, 0);
    // R3 hysteresis on CA
    req = "R3";
    step(0, 0, 1, 400, 0);
    step(0, 0, 1, 600, 100);
    step(0, 0, 1, 400, 150);
    // R4 arm on negative FE magnitude
    req = "R4"; step(0, 0, 1, 600, -250);
    // R5 same sign keeps armed, then loss of fok falls back to ramp
    req = "R5";
    step(0, 0, 1, 600, -100);
    step(0, 0, 1, 200, -90);
    req = "R4"; step(0, 0, 1, 600, 300);
    req = "R5"; step(0, 0, 1, 600, 0);
    // R6 ramp frozen while locked
    req = "R6";
    for (int i = 0; i < 4; i++) step(0, 0, 1, 700, 20 - 15 * i);
    // R9 gain switching
    req = "R9";
    step(0, 0, 0, 700, 0, 1, 0);
    step(0, 0, 0, 700, 0, 1, 0);
    step(0, 0, 0, 700, 0, 1, 1);
    step(0, 0, 1, 700, 5, 0, 1);
    step(0, 0, 0, 700, 5, 0, 1);
    step(0, 0, 0, 700, 5, 0, 1);
    // R7 dropout entered on the same edge as a gain command (R9 still applies)
    req = "R7";
    step(0, 0, 1, 200, 5, 1, 0);
    step(0, 0, 0, 200, 5, 1, 0);
    step(0, 0, 1, 400, 5);
    step(0, 0, 1, 600, 5);
    // R8 loss after limit, one-strobe restart, then ramp
    req = "R8";
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    // R10 stop with strobe; stop beats start in idle
    req = "R10";
    step(0, 1, 1, 600, 300);
    step(1, 1, 1, 600, 300);
    step(0, 0, 1, 600, 300);
    // R5 positive to negative crossing locks
    req = "R5";
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 600, 250);
    step(0, 0, 1, 600, 120);
    step(0, 0, 1, 600, -50);
    step(0, 0, 1, 600, -60);
    req = "R10"; step(0, 1, 0, 600, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule